// File: doc/BRIEF.md
# Vector Load/Store Offset Generator

This block turns one vectorised load or store with a displacement-form immediate into a stream of per-element effective addresses. After a start pulse it latches the operation: a vector length, a load/store flag, a stride mode, a 16-bit displacement, a 64-bit scalar base and an element width code. It then issues one element per clock. For each element it presents the element index, the rewritten 32-bit displacement and the effective address, together with a valid strobe.

The displacement is rewritten for each element according to the stride mode. Unit-stride adds the element index times the element width in bytes. Element-stride multiplies the displacement by the element index. Any other mode leaves the displacement untouched. A load takes its element step from a source step counter and a store takes it from a destination step counter. Both counters clear on start and advance together. A single-cycle done pulse marks the end of the vector. The memory access itself, predication and register-file work all happen outside this block.

Top module: `vls_offset_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `out_valid` and `done` are low.
- R2: The 16-bit displacement is sign-extended to 32 bits before any arithmetic, so 16'h8000 acts as -32768.
- R3: Mode code 2'b01 (unit-stride) gives a displacement of sext(D) + step × bytes, where width code 0/1/2/3 means 1/2/4/8 bytes. Example: VL=2, base 0x10, D=8, code 2 gives addresses 0x18 and 0x1C.
- R4: Mode code 2'b10 (element-stride) gives a displacement of sext(D) × step, kept to the low 32 bits.
- R5: Mode codes 2'b00 and 2'b11 pass sext(D) through unchanged for every element.
- R6: The step used is the element index, for loads (`is_store`=0) and for stores (`is_store`=1) alike.
- R7: `out_addr` equals the latched base plus the 32-bit displacement sign-extended to 64 bits, taken modulo 2^64.
- R8: When start is accepted at clock edge k with VL>0, element i appears with `out_valid` high and `out_idx`=i after edge k+1+i, one element per cycle, for i from 0 to VL-1.
- R9: `done` is high for exactly one cycle, after edge k+VL+1. With VL=0 it is high after edge k and no valid strobe appears.
- R10: A start pulse while `busy` is high is ignored. Changes to the operand inputs while `busy` is high have no effect on the elements issued.
- R11: A VL above the parameter MAXVL is clamped to MAXVL elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| vl | input | VL_W (7) | Requested vector length |
| is_store | input | 1 | 1 = store (destination step), 0 = load (source step) |
| mode | input | 2 | Stride mode code |
| disp | input | DISP_W (16) | Signed displacement immediate |
| base | input | ADDR_W (64) | Scalar base address |
| wlog | input | 2 | Element width code, log2 of bytes |
| busy | output | 1 | Elements are being issued |
| out_valid | output | 1 | Element outputs are valid |
| out_idx | output | VL_W (7) | Element index |
| out_disp | output | ADJ_W (32) | Adjusted displacement |
| out_addr | output | ADDR_W (64) | Effective address |
| done | output | 1 | One-cycle end-of-vector pulse |

## Verification
The bench sweeps every mode code and every width code, both load and store, and runs each case at vector lengths of 0, 1, 3, the maximum, and above the maximum. It also sweeps displacements that are small positive, small negative, most negative and most positive. The negative displacements separate correct sign extension from zero extension. The element-stride sweeps separate a multiply from a shift-add. Mixing loads and stores exposes a wrong step source. A base near 2^64 checks address wraparound, and the length sweep pins the exact cycle of each strobe and of done, including the empty vector and the clamp. One run pulses start and scrambles the operand inputs in mid-vector, and the elements it issues must stay unchanged.

// File: rtl/vls_pkg.sv
package vls_pkg;
   typedef enum logic [1:0] {
      STRIDE_NONE = 2'd0,
      STRIDE_UNIT = 2'd1,
      STRIDE_ELEM = 2'd2,
      STRIDE_RSVD = 2'd3
   } stride_e;
endpackage

// File: rtl/vls_step_ctrl.sv
module vls_step_ctrl #(
   parameter int VL_W  = 7,
   parameter int MAXVL = 127
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VL_W-1:0] vl,
   output logic            accept,
   output logic            busy,
   output logic            issue,
   output logic [VL_W-1:0] src_step,
   output logic [VL_W-1:0] dst_step,
   output logic            done
);
   localparam logic [VL_W-1:0] MAXV = VL_W'(MAXVL);

   logic [VL_W-1:0] len_q, vl_eff;
   logic            busy_q, fin_q, done_q, last;

   assign vl_eff = (vl > MAXV) ? MAXV : vl;
   assign accept = start & ~busy_q;
   assign issue  = busy_q;
   assign last   = (src_step == len_q - VL_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         fin_q    <= 1'b0;
         done_q   <= 1'b0;
         len_q    <= '0;
         src_step <= '0;
         dst_step <= '0;
      end else begin
         done_q <= fin_q | (accept & (vl_eff == '0));
         fin_q  <= busy_q & last;
         if (accept) begin
            busy_q   <= (vl_eff != '0);
            len_q    <= vl_eff;
            src_step <= '0;
            dst_step <= '0;
         end else if (busy_q) begin
            src_step <= src_step + VL_W'(1);
            dst_step <= dst_step + VL_W'(1);
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/vls_disp_adjust.sv
module vls_disp_adjust
   import vls_pkg::*;
#(
   parameter int DISP_W    = 16,
   parameter int ADJ_W     = 32,
   parameter int STEP_W    = 7,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  stride_e           mode,
   input  logic [DISP_W-1:0] disp,
   input  logic [STEP_W-1:0] step,
   input  logic [1:0]        wlog,
   output logic [ADJ_W-1:0]  adj
);
   localparam int EXT_W = ADJ_W - DISP_W;

   logic [ADJ_W-1:0] sd, step_x, unit_v, elem_v;

   assign sd     = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign step_x = ADJ_W'(step);
   assign unit_v = sd + (step_x << wlog);

   generate
      if (SHIFT_ADD) begin : g_shadd
         logic [ADJ_W-1:0] part [STEP_W+1];
         assign part[0] = '0;
         for (genvar b = 0; b < STEP_W; b++) begin : g_bit
            assign part[b+1] = part[b] + (step[b] ? (sd << b) : '0);
         end
         assign elem_v = part[STEP_W];
      end else begin : g_mul
         assign elem_v = sd * step_x;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         STRIDE_UNIT: adj = unit_v;
         STRIDE_ELEM: adj = elem_v;
         default:     adj = sd;
      endcase
   end
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen #(
   parameter int ADDR_W = 64,
   parameter int ADJ_W  = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADJ_W-1:0]  adj,
   output logic [ADDR_W-1:0] addr
);
   localparam int EXT_W = ADDR_W - ADJ_W;
   assign addr = base + {{EXT_W{adj[ADJ_W-1]}}, adj};
endmodule

// File: rtl/vls_offset_gen.sv
module vls_offset_gen
   import vls_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int DISP_W    = 16,
   parameter int ADJ_W     = 32,
   parameter int VL_W      = 7,
   parameter int MAXVL     = 127,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vl,
   input  logic              is_store,
   input  logic [1:0]        mode,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] base,
   input  logic [1:0]        wlog,
   output logic              busy,
   output logic              out_valid,
   output logic [VL_W-1:0]   out_idx,
   output logic [ADJ_W-1:0]  out_disp,
   output logic [ADDR_W-1:0] out_addr,
   output logic              done
);
   generate
      if (DISP_W > ADJ_W)           begin : g_e0 $error("DISP_W exceeds ADJ_W"); end
      if (ADJ_W > ADDR_W)           begin : g_e1 $error("ADJ_W exceeds ADDR_W"); end
      if (MAXVL < 1)                begin : g_e2 $error("MAXVL below 1"); end
      if (MAXVL > (1 << VL_W) - 1)  begin : g_e3 $error("MAXVL does not fit VL_W"); end
   endgenerate

   logic              accept, issue;
   logic [VL_W-1:0]   src_step, dst_step, step;
   logic              st_q;
   stride_e           mode_q;
   logic [DISP_W-1:0] disp_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        wlog_q;
   logic [ADJ_W-1:0]  adj;
   logic [ADDR_W-1:0] addr;

   vls_step_ctrl #(.VL_W(VL_W), .MAXVL(MAXVL)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
      .accept(accept), .busy(busy), .issue(issue),
      .src_step(src_step), .dst_step(dst_step), .done(done));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= 1'b0;
         mode_q <= STRIDE_NONE;
         disp_q <= '0;
         base_q <= '0;
         wlog_q <= '0;
      end else if (accept) begin
         st_q   <= is_store;
         mode_q <= stride_e'(mode);
         disp_q <= disp;
         base_q <= base;
         wlog_q <= wlog;
      end
   end

   assign step = st_q ? dst_step : src_step;

   vls_disp_adjust #(.DISP_W(DISP_W), .ADJ_W(ADJ_W), .STEP_W(VL_W),
                     .SHIFT_ADD(SHIFT_ADD)) u_adj (
      .mode(mode_q), .disp(disp_q), .step(step), .wlog(wlog_q), .adj(adj));

   vls_addr_gen #(.ADDR_W(ADDR_W), .ADJ_W(ADJ_W)) u_addr (
      .base(base_q), .adj(adj), .addr(addr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_disp  <= '0;
         out_addr  <= '0;
      end else begin
         out_valid <= issue;
         if (issue) begin
            out_idx  <= step;
            out_disp <= adj;
            out_addr <= addr;
         end
      end
   end
endmodule

// File: rtl/vls_offset_gen_chk.sv
module vls_offset_gen_chk #(
   parameter int VL_W  = 7,
   parameter int MAXVL = 127
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            out_valid,
   input logic [VL_W-1:0] out_idx,
   input logic            done
);
   p_first_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> (out_valid && out_idx == '0));

   p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> out_idx == $past(out_idx) + VL_W'(1));

   p_valid_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(busy));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);

   p_idx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_idx < VL_W'(MAXVL));
endmodule

bind vls_offset_gen vls_offset_gen_chk #(.VL_W(VL_W), .MAXVL(MAXVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
   .out_idx(out_idx), .done(done));

// File: tb/sim_vls_offset_gen.sv
module sim_vls_offset_gen;
   localparam int MAXV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  vl = '0;
   logic        is_store = 1'b0;
   logic [1:0]  mode = '0;
   logic [15:0] disp = '0;
   logic [63:0] base = '0;
   logic [1:0]  wlog = '0;
   logic        busy, out_valid, done;
   logic [6:0]  out_idx;
   logic [31:0] out_disp;
   logic [63:0] out_addr;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   vls_offset_gen #(.MAXVL(MAXV)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .is_store(is_store),
      .mode(mode), .disp(disp), .base(base), .wlog(wlog), .busy(busy),
      .out_valid(out_valid), .out_idx(out_idx), .out_disp(out_disp),
      .out_addr(out_addr), .done(done));

   function automatic logic [31:0] exp_adj(input logic [1:0] md, input logic [15:0] d,
                                           input int step, input logic [1:0] w);
      logic [31:0] sd = {{16{d[15]}}, d};
      case (md)
         2'd1:    return sd + (32'(step) << w);
         2'd2:    return sd * 32'(step);
         default: return sd;
      endcase
   endfunction

   task automatic run_vec(input int vlv, input bit st, input logic [1:0] md,
                          input logic [15:0] d, input logic [63:0] b,
                          input logic [1:0] w, input bit inj);
      int vle = (vlv > MAXV) ? MAXV : vlv;
      int nv = 0;
      bit tim_ok = 1'b1;
      string tg;
      logic [31:0] ea;
      logic [63:0] eaddr;
      tg = (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R5";
      @(negedge clk);
      vl = 7'(vlv); is_store = st; mode = md; disp = d; base = b; wlog = w;
      start = 1'b1;
      for (int c = 0; c < MAXV + 4; c++) begin
         @(negedge clk);
         if (c == 0) begin
            start = inj;
            if (inj) begin   // R10: scrambled operands while busy
               vl = 7'd3; mode = ~md; disp = ~d; base = ~b; wlog = ~w; is_store = ~st;
            end
         end else if (c == 1) start = 1'b0;
         if (out_valid !== (c >= 1 && c <= vle) ||
             done !== ((vle == 0) ? (c == 0) : (c == vle + 1))) tim_ok = 1'b0;
         if (out_valid) begin
            ea = exp_adj(md, d, nv, w);
            eaddr = b + {{32{ea[31]}}, ea};
            checks++;
            if (out_idx !== 7'(nv) || out_disp !== ea || out_addr !== eaddr) begin
               errors++;
               $display("FAIL %s/R2/R6/R7%s idx=%0d disp=%h addr=%h expected idx=%0d disp=%h addr=%h (st=%0d)",
                        tg, inj ? "/R10" : "", out_idx, out_disp, out_addr, nv, ea, eaddr, st);
            end
            nv++;
         end
      end
      checks++;
      if (!tim_ok || nv != vle) begin
         errors++;
         $display("FAIL R8/R9%s timing vl=%0d: valids=%0d expected %0d",
                  (vlv > MAXV) ? "/R11" : "", vlv, nv, vle);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int vls [5] = '{0, 1, 3, 8, 11};
      logic [15:0] ds [4] = '{16'h0008, 16'hFFFC, 16'h8000, 16'h7FFF};
      logic [63:0] bs [2] = '{64'h10, 64'hFFFF_FFFF_FFFF_FFF8};
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || out_valid !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset busy=%b valid=%b done=%b expected 000", busy, out_valid, done);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (busy !== 1'b0 || out_valid !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset busy=%b valid=%b done=%b expected 000", busy, out_valid, done);
      end
      // R3 worked example: 0x18 then 0x1C
      run_vec(2, 1'b1, 2'd1, 16'h0008, 64'h10, 2'd2, 1'b0);
      run_vec(2, 1'b0, 2'd1, 16'h0008, 64'h10, 2'd2, 1'b0);
      // R10 start and operand changes while busy
      run_vec(6, 1'b0, 2'd2, 16'hFFF0, 64'h1000, 2'd1, 1'b1);
      // R2..R9, R11 sweep
      for (int m = 0; m < 4; m++)
         for (int w = 0; w < 4; w++)
            for (int s = 0; s < 2; s++)
               for (int di = 0; di < 4; di++)
                  for (int vi = 0; vi < 5; vi++)
                     run_vec(vls[vi], s[0], 2'(m), ds[di], bs[(m + w + di) % 2], 2'(w), 1'b0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule